// File: doc/BRIEF.md
# Asynchronous SRAM Interface Controller

This controller lets synchronous logic use an external asynchronous 128K x 16 static RAM. A requester offers one access at a time through a valid/ready handshake: a word address, a write flag, a 16-bit write word and one enable per byte. The controller then drives the memory pins. It holds each pin phase for a whole number of clock ticks. The tick counts are derived, rounding up, from the memory's minimum nanosecond timings and a clock-period parameter. Read results come back in a register with a one-cycle valid strobe.

The memory takes two chip selects of opposite polarity, an output enable, a write strobe and one strobe per byte lane. The data bus is split into an outgoing word, an incoming word and a drive enable. When no request arrives for a set number of idle cycles, the controller deselects the memory to put it in low-power standby. A request made while in standby first waits a recovery time with the chip selected, and only then does the access begin.

Top module: `async_sram_ctrl`

## Requirements
- R1: Reset leaves the memory in standby (`sram_ce1_n`=1, `sram_ce2`=0), with `sram_oe_n`, `sram_we_n`, `sram_lb_n` and `sram_ub_n` high, `sram_dq_oe` low, `req_ready` high and `rdata_valid` low.
- R2: Whenever `sram_oe_n` or `sram_we_n` is low, the chip is selected (`sram_ce1_n`=0 and `sram_ce2`=1). Output enable and write strobe are never low together.
- R3: A read holds `sram_oe_n` low and `sram_we_n` high for exactly RD = ceil(55 ns / period) consecutive cycles, with a stable address. `sram_lb_n` is low only if `req_be[0]` is set, and `sram_ub_n` is low only if `req_be[1]` is set.
- R4: A read accepted while ready and not in standby raises `rdata_valid` for exactly one cycle, RD cycles after the accepting edge. `rdata` bits [7:0] hold the memory's low lane if `req_be[0]` is set, else 0. Bits [15:8] hold the high lane if `req_be[1]` is set, else 0.
- R5: A write holds `sram_we_n` low for exactly WP = ceil(max(40 ns, 45 ns) / period) cycles. During that time `sram_oe_n` is high, and the address, the lane strobes and `sram_dq_out` are stable. Each lane whose enable is set is written with its byte of `req_wdata`.
- R6: `sram_dq_oe` is high from the first cycle of `sram_we_n` low through the cycle right after `sram_we_n` rises, and at no other time. It is never high while `sram_oe_n` is low.
- R7: A write occupies WC = max(ceil(55 ns / period), WP+1) cycles from the accepting edge until `req_ready` returns.
- R8: `req_ready` is low while an access or a recovery is in progress, and high when idle or in standby.
- R9: A write with `req_be`=0 produces no `sram_we_n` pulse and changes no memory content. From idle, `req_ready` stays high.
- R10: After IDLE_LIMIT consecutive idle cycles with no request accepted, the controller enters standby (`sram_ce1_n`=1, `sram_ce2`=0).
- R11: A request accepted in standby selects the chip and waits RCV = ceil(55 ns / period) cycles before `sram_oe_n` or `sram_we_n` falls. Every result then arrives RCV cycles later than it would from idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request can be accepted this cycle |
| req_addr | input | ADDR_W | Word address |
| req_we | input | 1 | 1 = write, 0 = read |
| req_wdata | input | DATA_W | Write word |
| req_be | input | 2 | Lane enables, bit 0 = low byte, bit 1 = high byte |
| rdata | output | DATA_W | Captured read word, disabled lanes zero |
| rdata_valid | output | 1 | One-cycle strobe marking `rdata` fresh |
| sram_addr | output | ADDR_W | Memory address |
| sram_ce1_n | output | 1 | Chip select, active low |
| sram_ce2 | output | 1 | Chip select, active high |
| sram_oe_n | output | 1 | Output enable, active low |
| sram_we_n | output | 1 | Write strobe, active low |
| sram_lb_n | output | 1 | Low-lane strobe, active low |
| sram_ub_n | output | 1 | High-lane strobe, active low |
| sram_dq_out | output | DATA_W | Data driven toward the memory |
| sram_dq_oe | output | 1 | Drive enable for `sram_dq_out` |
| sram_dq_in | input | DATA_W | Data returned by the memory |

## Verification
At the 125 MHz bench clock the tick counts are RD = 7, WP = 6, WC = 7 and RCV = 7, with standby after 8 idle cycles. Counting from the negative clock edge just after the accepting edge, call it sample 1: the read strobe arrives at sample RD+1, the first pin strobe at sample 1, and both shift by RCV when the request starts in standby. The bench samples every output on negative edges and counts, per access, how many samples show each strobe low, how many show the bus driven and how many show ready low. It compares those counts and the strobe position with the figures above, and checks standby entry at exactly samples IDLE_LIMIT and IDLE_LIMIT+1 after the return to idle.

// File: rtl/async_sram_ctrl.sv
module async_sram_ctrl #(
  parameter int ADDR_W        = 17,
  parameter int DATA_W        = 16,
  parameter int CLK_PERIOD_NS = 10,
  parameter int T_RC_NS       = 55,
  parameter int T_WP_NS       = 40,
  parameter int T_CW_NS       = 45,
  parameter int T_WC_NS       = 55,
  parameter int IDLE_LIMIT    = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_we,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [1:0]        req_be,
  output logic [DATA_W-1:0] rdata,
  output logic              rdata_valid,
  output logic [ADDR_W-1:0] sram_addr,
  output logic              sram_ce1_n,
  output logic              sram_ce2,
  output logic              sram_oe_n,
  output logic              sram_we_n,
  output logic              sram_lb_n,
  output logic              sram_ub_n,
  output logic [DATA_W-1:0] sram_dq_out,
  output logic              sram_dq_oe,
  input  logic [DATA_W-1:0] sram_dq_in
);

  localparam int LANE   = DATA_W / 2;
  localparam int RD_T   = (T_RC_NS + CLK_PERIOD_NS - 1) / CLK_PERIOD_NS;
  localparam int WLO_NS = (T_WP_NS > T_CW_NS) ? T_WP_NS : T_CW_NS;
  localparam int WP_T   = (WLO_NS + CLK_PERIOD_NS - 1) / CLK_PERIOD_NS;
  localparam int WC_RAW = (T_WC_NS + CLK_PERIOD_NS - 1) / CLK_PERIOD_NS;
  localparam int WC_T   = (WC_RAW > WP_T) ? WC_RAW : WP_T + 1;
  localparam int WR_T   = WC_T - WP_T;
  localparam int RCV_T  = RD_T;
  localparam int MAX_T  = (RD_T > WC_T) ? RD_T : WC_T;
  localparam int CNT_W  = $clog2(MAX_T + 1) + 1;
  localparam int IDL_W  = $clog2(IDLE_LIMIT + 1) + 1;

  typedef enum logic [2:0] {
    S_STBY, S_RECOVER, S_IDLE, S_READ, S_WRITE, S_WREC
  } state_t;

  state_t              state;
  logic [CNT_W-1:0]    cnt;
  logic [IDL_W-1:0]    idle_cnt;
  logic [ADDR_W-1:0]   a_q;
  logic [DATA_W-1:0]   d_q;
  logic [1:0]          be_q;
  logic                we_q;
  logic [DATA_W-1:0]   rdata_q;
  logic                rvalid_q;

  wire accept = req_valid && req_ready;
  wire active = (state == S_READ) || (state == S_WRITE);
  wire [DATA_W-1:0] lane_mask = {{LANE{be_q[1]}}, {LANE{be_q[0]}}};

  assign req_ready   = (state == S_IDLE) || (state == S_STBY);
  assign rdata       = rdata_q;
  assign rdata_valid = rvalid_q;
  assign sram_addr   = a_q;
  assign sram_ce1_n  = (state == S_STBY);
  assign sram_ce2    = (state != S_STBY);
  assign sram_oe_n   = (state != S_READ);
  assign sram_we_n   = (state != S_WRITE);
  assign sram_lb_n   = !(active && be_q[0]);
  assign sram_ub_n   = !(active && be_q[1]);
  assign sram_dq_out = d_q;
  assign sram_dq_oe  = (state == S_WRITE) ||
                       ((state == S_WREC) && (cnt == CNT_W'(WR_T - 1)));

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= S_STBY;
      cnt      <= '0;
      idle_cnt <= '0;
      a_q      <= '0;
      d_q      <= '0;
      be_q     <= '0;
      we_q     <= 1'b0;
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
    end else begin
      rvalid_q <= 1'b0;
      if (state != S_IDLE) idle_cnt <= '0;
      if (accept) begin
        a_q  <= req_addr;
        d_q  <= req_wdata;
        be_q <= req_be;
        we_q <= req_we;
      end
      case (state)
        S_STBY: if (accept) begin
          state <= S_RECOVER;
          cnt   <= CNT_W'(RCV_T - 1);
        end
        S_IDLE: begin
          if (accept) begin
            idle_cnt <= '0;
            if (req_we && req_be == 2'b00) begin
              state <= S_IDLE;
            end else if (req_we) begin
              state <= S_WRITE;
              cnt   <= CNT_W'(WP_T - 1);
            end else begin
              state <= S_READ;
              cnt   <= CNT_W'(RD_T - 1);
            end
          end else if (idle_cnt == IDL_W'(IDLE_LIMIT - 1)) begin
            state <= S_STBY;
          end else begin
            idle_cnt <= idle_cnt + 1'b1;
          end
        end
        S_RECOVER: begin
          if (cnt != '0) begin
            cnt <= cnt - 1'b1;
          end else if (we_q && be_q == 2'b00) begin
            state <= S_IDLE;
          end else if (we_q) begin
            state <= S_WRITE;
            cnt   <= CNT_W'(WP_T - 1);
          end else begin
            state <= S_READ;
            cnt   <= CNT_W'(RD_T - 1);
          end
        end
        S_READ: begin
          if (cnt != '0) begin
            cnt <= cnt - 1'b1;
          end else begin
            rdata_q  <= sram_dq_in & lane_mask;
            rvalid_q <= 1'b1;
            state    <= S_IDLE;
          end
        end
        S_WRITE: begin
          if (cnt != '0) begin
            cnt <= cnt - 1'b1;
          end else begin
            state <= S_WREC;
            cnt   <= CNT_W'(WR_T - 1);
          end
        end
        S_WREC: begin
          if (cnt != '0) cnt <= cnt - 1'b1;
          else state <= S_IDLE;
        end
        default: state <= S_STBY;
      endcase
    end
  end

  logic [CNT_W:0] we_run, oe_run;
  logic [15:0]    sel_run;
  always_ff @(posedge clk) begin
    if (rst) begin
      we_run  <= '0;
      oe_run  <= '0;
      sel_run <= '0;
    end else begin
      we_run  <= sram_we_n ? '0 : we_run + 1'b1;
      oe_run  <= sram_oe_n ? '0 : oe_run + 1'b1;
      sel_run <= sram_ce1_n ? '0 : ((sel_run == 16'hFFFF) ? sel_run : sel_run + 1'b1);
    end
  end

  p_selected_r2: assert property (@(posedge clk) disable iff (rst)
    (!sram_oe_n || !sram_we_n) |-> (!sram_ce1_n && sram_ce2));
  p_oe_we_excl_r2: assert property (@(posedge clk) disable iff (rst)
    !(!sram_oe_n && !sram_we_n));
  p_read_len_r3: assert property (@(posedge clk) disable iff (rst)
    $rose(sram_oe_n) |-> (oe_run == (CNT_W+1)'(RD_T)));
  p_read_addr_r3: assert property (@(posedge clk) disable iff (rst)
    (!sram_oe_n && $past(!sram_oe_n)) |-> $stable(sram_addr));
  p_rvalid_pulse_r4: assert property (@(posedge clk) disable iff (rst)
    rdata_valid |=> !rdata_valid);
  p_write_len_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(sram_we_n) |-> (we_run == (CNT_W+1)'(WP_T)));
  p_write_stable_r5: assert property (@(posedge clk) disable iff (rst)
    (!sram_we_n && $past(!sram_we_n)) |->
      ($stable(sram_addr) && $stable(sram_dq_out) && $stable(sram_lb_n) && $stable(sram_ub_n)));
  p_no_contention_r6: assert property (@(posedge clk) disable iff (rst)
    sram_dq_oe |-> sram_oe_n);
  p_drive_in_write_r6: assert property (@(posedge clk) disable iff (rst)
    !sram_we_n |-> sram_dq_oe);
  p_ready_quiet_r8: assert property (@(posedge clk) disable iff (rst)
    req_ready |-> (sram_oe_n && sram_we_n));
  p_recovery_r11: assert property (@(posedge clk) disable iff (rst)
    (!sram_oe_n || !sram_we_n) |-> (sel_run >= 16'(RCV_T)));

endmodule

// File: tb/test_async_sram_ctrl.sv
module test_async_sram_ctrl;
  localparam int AW   = 6;
  localparam int PER  = 8;
  localparam int LIM  = 8;
  localparam int RD   = (55 + PER - 1) / PER;
  localparam int WP   = (45 + PER - 1) / PER;
  localparam int WC   = ((55 + PER - 1) / PER > WP) ? (55 + PER - 1) / PER : WP + 1;
  localparam int RCV  = RD;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 1'b0, req_we = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic [1:0] req_be = '0;
  logic req_ready, rdata_valid;
  logic [15:0] rdata, dq_out, dq_in;
  logic [AW-1:0] sram_addr;
  logic ce1_n, ce2, oe_n, we_n, lb_n, ub_n, dq_oe;

  int checks = 0, fails = 0;
  bit finished = 0;
  logic [15:0] mem [64];
  logic [15:0] ref_mem [64];

  always #(PER/2) clk = ~clk;

  async_sram_ctrl #(.ADDR_W(AW), .DATA_W(16), .CLK_PERIOD_NS(PER), .IDLE_LIMIT(LIM)) i_async_sram_ctrl (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_we(req_we), .req_wdata(req_wdata), .req_be(req_be),
    .rdata(rdata), .rdata_valid(rdata_valid), .sram_addr(sram_addr),
    .sram_ce1_n(ce1_n), .sram_ce2(ce2), .sram_oe_n(oe_n), .sram_we_n(we_n),
    .sram_lb_n(lb_n), .sram_ub_n(ub_n), .sram_dq_out(dq_out), .sram_dq_oe(dq_oe),
    .sram_dq_in(dq_in));

  wire sel = !ce1_n && ce2;
  wire rd_on = sel && !oe_n && we_n;
  assign dq_in = {(rd_on && !ub_n) ? mem[sram_addr][15:8] : 8'hEE,
                  (rd_on && !lb_n) ? mem[sram_addr][7:0]  : 8'hEE};

  always @(posedge clk) begin
    if (sel && !we_n) begin
      if (!lb_n) mem[sram_addr][7:0]  <= dq_oe ? dq_out[7:0]  : 8'h00;
      if (!ub_n) mem[sram_addr][15:8] <= dq_oe ? dq_out[15:8] : 8'h00;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic run_access(input logic we, input logic [AW-1:0] a, input logic [15:0] d,
                            input logic [1:0] be, input bit from_stby);
    int we_lo = 0, oe_lo = 0, drv = 0, busy = 0, vat = 0, npulse = 0, first = 0;
    int pre = from_stby ? RCV : 0;
    bit done = 0;
    bit lane_ok = 1;
    logic [15:0] got = '0, expv;
    @(negedge clk);
    chk(req_ready == 1'b1, "R8 ready before request", req_ready, 1);
    req_valid = 1'b1; req_we = we; req_addr = a; req_wdata = d; req_be = be;
    @(negedge clk);
    req_valid = 1'b0;
    for (int k = 1; k <= 60 && !done; k++) begin
      if (!we_n) we_lo++;
      if (!oe_n) oe_lo++;
      if (dq_oe) drv++;
      if ((!oe_n || !we_n) && (lb_n != !be[0] || ub_n != !be[1])) lane_ok = 0;
      if (first == 0 && (!oe_n || !we_n)) first = k;
      if (rdata_valid) begin vat = k; npulse++; got = rdata; end
      if (req_ready) done = 1;
      else begin busy++; @(negedge clk); end
    end
    if (we && be == 2'b00) begin
      chk(we_lo == 0, "R9 no write strobe for empty enables", we_lo, 0);
      chk(busy == pre, "R9 ready timing for empty write", busy, pre);
    end else if (we) begin
      chk(we_lo == WP, "R5 write strobe width", we_lo, WP);
      chk(drv == WP + 1, "R6 bus drive window", drv, WP + 1);
      chk(busy == pre + WC, "R7 write occupancy", busy, pre + WC);
      chk(oe_lo == 0, "R5 output enable high in write", oe_lo, 0);
      chk(lane_ok, "R5 lane strobes follow enables", lane_ok, 1);
      chk(first == pre + 1, "R11 strobe after recovery", first, pre + 1);
      if (be[0]) ref_mem[a][7:0]  = d[7:0];
      if (be[1]) ref_mem[a][15:8] = d[15:8];
    end else begin
      expv = {be[1] ? ref_mem[a][15:8] : 8'h00, be[0] ? ref_mem[a][7:0] : 8'h00};
      chk(oe_lo == RD, "R3 read strobe width", oe_lo, RD);
      chk(lane_ok, "R3 lane strobes follow enables", lane_ok, 1);
      chk(drv == 0, "R6 no drive during read", drv, 0);
      chk(vat == pre + RD + 1, "R4 read valid timing", vat, pre + RD + 1);
      chk(npulse == 1, "R4 single valid pulse", npulse, 1);
      chk(got == expv, "R4 read data", got, expv);
      chk(busy == pre + RD, "R8 ready low during read", busy, pre + RD);
      chk(first == pre + 1, "R11 strobe after recovery", first, pre + 1);
    end
  endtask

  task automatic wait_standby;
    repeat (LIM - 1) @(negedge clk);
    chk(ce1_n == 1'b0, "R10 still selected before limit", ce1_n, 0);
    @(negedge clk);
    chk(ce1_n == 1'b1 && ce2 == 1'b0, "R10 standby entered", {ce1_n, ce2}, 2'b10);
    chk(req_ready == 1'b1, "R8 ready in standby", req_ready, 1);
  endtask

  initial begin
    for (int i = 0; i < 64; i++) begin
      mem[i] = 16'hC3A5 ^ 16'(i * 37);
      ref_mem[i] = mem[i];
    end
    repeat (3) @(negedge clk);
    chk(ce1_n == 1 && ce2 == 0 && oe_n == 1 && we_n == 1 && lb_n == 1 && ub_n == 1,
        "R1 reset pins", {ce1_n, ce2, oe_n, we_n, lb_n, ub_n}, 6'b101111);
    chk(dq_oe == 0 && req_ready == 1 && rdata_valid == 0, "R1 reset status",
        {dq_oe, req_ready, rdata_valid}, 3'b010);
    rst = 1'b0;
    run_access(1'b1, 6'd0, 16'h1234, 2'b11, 1'b1);
    for (int a = 0; a < 64; a++)
      run_access(1'b1, AW'(a), 16'(a * 16'h0101) ^ 16'h5A3C, 2'(a % 4), 1'b0);
    for (int a = 0; a < 64; a++)
      run_access(1'b0, AW'(a), 16'h0, 2'b11, 1'b0);
    for (int a = 0; a < 64; a++)
      run_access(1'b0, AW'(a), 16'h0, 2'(a % 4), 1'b0);
    wait_standby();
    run_access(1'b0, 6'd5, 16'h0, 2'b11, 1'b1);
    wait_standby();
    run_access(1'b1, 6'd9, 16'hBEEF, 2'b10, 1'b1);
    wait_standby();
    run_access(1'b1, 6'd9, 16'h0F0F, 2'b00, 1'b1);
    run_access(1'b0, 6'd9, 16'h0, 2'b11, 1'b0);
    run_access(1'b1, 6'd17, 16'hA1B2, 2'b01, 1'b0);
    run_access(1'b0, 6'd17, 16'h0, 2'b11, 1'b0);
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; fails++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule